// File: doc/BRIEF.md
# Multi-Master Serial Clock Synchronizer

This block produces one node's serial clock on a shared open-drain clock line. The line is a wired-AND: every master either pulls it low or lets it float high. The block never drives the line high. It times a low phase and a high phase from two programmable count values. Each phase's timer starts only when the synchronized bus level is seen in that state, so the node runs in lockstep with every other master on the line.

The sampled line level passes through a two-flop synchronizer and then an edge detector. The detector produces one-cycle strobes on each observed rising and falling edge, for use by the data shifter.

A low phase ends only when the slowest master lets go, so the combined clock's low time is set by the longest low setting. A high phase ends as soon as any master times out and pulls the line down, so the combined high time is set by the shortest high setting. A node whose high timer is still running when the line falls drops that count and starts a fresh low phase.

Top module: `scl_clock_sync`

## Requirements
- R1: `scl_pull` = 1 means the node pulls the line low and 0 means it releases it. The node's pull ends when its own low count expires, even if another master still holds the line low.
- R2: `rise_stb` and `fall_stb` are one-cycle pulses and never coincide. Take t as the system-clock sample at which the strobe is high. `rise_stb` is high exactly when the line was 1 at sample t-2 and 0 at sample t-3. `fall_stb` is high exactly when the line was 0 at sample t-2 and 1 at sample t-3.
- R3: With one master on the line and low count value L (0 to 2^CNT_W-1), the line stays low for L+4 system clock cycles. That is the synchronizer and edge-detector latency (3 cycles) plus L+1 counted cycles.
- R4: With one master on the line and high count value H, the line stays high for H+4 cycles.
- R5: The low timer starts from the observed falling edge whoever caused it. With several masters, the line low time is the largest L among them plus 4.
- R6: The high timer runs only after the line is seen high. With several masters, the line high time is the smallest H among them plus 4.
- R7: A falling edge observed during the node's high count drops that count. One cycle later the node pulls low and runs a fresh low count.
- R8: While `en` is 0, the node releases the line (from the cycle after `en` falls), emits no strobes and clears both timers. A later enable starts cleanly from the high-wait phase.
- R9: `lo_cnt` is captured when a low count starts and `hi_cnt` when a high count starts. A change during a phase affects only later phases.
- R10: After reset, `scl_pull`, `rise_stb` and `fall_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables clock generation |
| lo_cnt | input | CNT_W | Low phase count value L |
| hi_cnt | input | CNT_W | High phase count value H |
| scl_in | input | 1 | Sampled level of the shared clock line |
| scl_pull | output | 1 | 1 = pull the clock line low |
| rise_stb | output | 1 | Observed rising edge strobe |
| fall_stb | output | 1 | Observed falling edge strobe |

## Verification
The bench builds the block with CNT_W = 6. The all-ones count of 63 is therefore reachable in a short run, so both the zero and the full-scale period boundaries are measured. Two instances drive one modeled wired-AND line. This puts the stretched low phase, the shortened high phase and the dropped high count within reach, with each node in turn being the slower or the faster one. The line's low and high times are measured against values worked out from the counts.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WAIT_HI = 3'd1,
    PH_HIGH    = 3'd2,
    PH_WAIT_LO = 3'd3,
    PH_LOW     = 3'd4
  } phase_t;

  localparam int TMR_LO = 0;
  localparam int TMR_HI = 1;
  localparam int NUM_TMR = 2;

  // {rise, fall} from the current and previous synchronized level
  function automatic logic [1:0] edge_pair(input logic now_lvl, input logic prev_lvl);
    return {now_lvl & ~prev_lvl, ~now_lvl & prev_lvl};
  endfunction

endpackage

// File: rtl/scl_edge_sync.sv
module scl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  import scl_sync_pkg::*;

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_lvl;
  logic [1:0]    edges;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain    <= '1;
      prev_lvl <= 1'b1;
    end else begin
      chain    <= {chain[LAST-1:0], line_in};
      prev_lvl <= chain[LAST];
    end
  end

  assign lvl   = chain[LAST];
  assign edges = edge_pair(chain[LAST], prev_lvl);
  assign rise  = edges[1];
  assign fall  = edges[0];

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (run)   cnt <= count_step(cnt);
  end

  assign done = run && (cnt == '0);

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_sync_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   bus_lvl,
  input  logic   bus_fall,
  input  logic   lo_done,
  input  logic   hi_done,
  output phase_t phase,
  output logic   load_lo,
  output logic   load_hi,
  output logic   run_lo,
  output logic   run_hi,
  output logic   clr
);

  phase_t nxt;

  always_comb begin
    nxt = phase;
    if (!en) begin
      nxt = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:    nxt = PH_WAIT_HI;
        PH_WAIT_HI: if (bus_lvl) nxt = PH_HIGH;
        PH_HIGH: begin
          if (bus_fall)     nxt = PH_LOW;
          else if (hi_done) nxt = PH_WAIT_LO;
        end
        PH_WAIT_LO: if (!bus_lvl) nxt = PH_LOW;
        PH_LOW:     if (lo_done) nxt = PH_WAIT_HI;
        default:    nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  assign load_lo = (nxt == PH_LOW)  && (phase != PH_LOW);
  assign load_hi = (nxt == PH_HIGH) && (phase != PH_HIGH);
  assign run_lo  = (phase == PH_LOW);
  assign run_hi  = (phase == PH_HIGH);
  assign clr     = !en;

endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic             scl_in,
  output logic             scl_pull,
  output logic             rise_stb,
  output logic             fall_stb
);
  import scl_sync_pkg::*;

  logic   bus_lvl, raw_rise, raw_fall;
  phase_t phase;
  logic   clr;
  logic   active;
  logic   in_high;
  logic   lo_done, hi_done;

  logic [NUM_TMR-1:0] t_load, t_run, t_done;
  logic [CNT_W-1:0]   t_val [NUM_TMR];

  scl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (scl_in),
    .lvl     (bus_lvl),
    .rise    (raw_rise),
    .fall    (raw_fall)
  );

  scl_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .bus_lvl  (bus_lvl),
    .bus_fall (raw_fall),
    .lo_done  (lo_done),
    .hi_done  (hi_done),
    .phase    (phase),
    .load_lo  (t_load[TMR_LO]),
    .load_hi  (t_load[TMR_HI]),
    .run_lo   (t_run[TMR_LO]),
    .run_hi   (t_run[TMR_HI]),
    .clr      (clr)
  );

  assign t_val[TMR_LO] = lo_cnt;
  assign t_val[TMR_HI] = hi_cnt;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    scl_phase_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load     (t_load[g]),
      .load_val (t_val[g]),
      .run      (t_run[g]),
      .done     (t_done[g])
    );
  end

  assign lo_done  = t_done[TMR_LO];
  assign hi_done  = t_done[TMR_HI];
  assign in_high  = (phase == PH_HIGH);
  assign active   = (phase != PH_IDLE);
  assign scl_pull = (phase == PH_WAIT_LO) || (phase == PH_LOW);
  assign rise_stb = raw_rise && active;
  assign fall_stb = raw_fall && active;

endmodule

// File: rtl/scl_clock_sync_chk.sv
module scl_clock_sync_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_pull,
  input logic rise_stb,
  input logic fall_stb,
  input logic lo_done,
  input logic hi_done,
  input logic in_high
);

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull && !rise_stb && !fall_stb));

  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  a_r2_rise_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb);

  a_r2_fall_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);

  a_r1_release_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lo_done) |=> !scl_pull);

  a_r6_pull_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hi_done) |=> scl_pull);

  a_r7_abandon_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_high && fall_stb) |=> scl_pull);

endmodule

bind scl_clock_sync scl_clock_sync_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .scl_pull (scl_pull),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb),
  .lo_done  (lo_done),
  .hi_done  (hi_done),
  .in_high  (in_high)
);

// File: tb/test_scl_clock_sync.sv
module test_scl_clock_sync;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_a = 1'b0, en_b = 1'b0;
  logic [CNT_W-1:0] lo_a = '0, hi_a = '0, lo_b = '0, hi_b = '0;
  logic pull_a, rise_a, fall_a, pull_b, rise_b, fall_b;
  wire  bus = ~(pull_a | pull_b);

  always #10 clk = ~clk;

  scl_clock_sync #(.CNT_W(CNT_W)) i_scl_clock_sync (
    .clk(clk), .rst_n(rst_n), .en(en_a), .lo_cnt(lo_a), .hi_cnt(hi_a),
    .scl_in(bus), .scl_pull(pull_a), .rise_stb(rise_a), .fall_stb(fall_a));

  scl_clock_sync #(.CNT_W(CNT_W)) i_peer (
    .clk(clk), .rst_n(rst_n), .en(en_b), .lo_cnt(lo_b), .hi_cnt(hi_b),
    .scl_in(bus), .scl_pull(pull_b), .rise_stb(rise_b), .fall_stb(fall_b));

  typedef struct { bit is_low; int len; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  bit measure = 0;
  bit done_flag = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures line phases and checks strobe timing
  int t_fall = 0, t_rise = 0;
  bit fs = 0, rs = 0;
  logic h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;
  logic [3:0] ena_hist = '0;
  int quiet_viol = 0;
  bit quiet_watch = 0;
  int rel_while_low = 0;

  always @(negedge clk) begin
    exp_t e;
    int len;
    logic exp_r, exp_f;
    cyc++;
    ena_hist = {ena_hist[2:0], en_a};
    if (rst_n && ena_hist == 4'b1111) begin
      exp_r = h2 & ~h3;
      exp_f = ~h2 & h3;
      if (exp_r || rise_a) check(rise_a == exp_r, "R2 rise strobe", int'(rise_a), int'(exp_r));
      if (exp_f || fall_a) check(fall_a == exp_f, "R2 fall strobe", int'(fall_a), int'(exp_f));
    end
    if (quiet_watch && (pull_a || rise_a || fall_a)) quiet_viol++;
    if (en_a && en_b && !pull_a && !bus) rel_while_low++;
    if (!measure) begin
      fs = 0; rs = 0;
    end else if (bus != h1) begin
      if (bus) begin
        if (fs) begin
          len = cyc - t_fall;
          if (q.size() == 0) check(0, "unexpected low phase", len, -1);
          else begin
            e = q.pop_front();
            check(e.is_low && len == e.len, e.tag, len, e.len);
          end
        end
        t_rise = cyc; rs = 1;
      end else begin
        if (rs) begin
          len = cyc - t_rise;
          if (q.size() == 0) check(0, "unexpected high phase", len, -1);
          else begin
            e = q.pop_front();
            check(!e.is_low && len == e.len, e.tag, len, e.len);
          end
        end
        t_fall = cyc; fs = 1;
      end
    end
    h3 = h2; h2 = h1; h1 = bus;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done_flag) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic push(input int lo_len, input int hi_len, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      q.push_back('{1'b1, lo_len, {tag, " low"}});
      q.push_back('{1'b0, hi_len, {tag, " high"}});
    end
  endtask

  task automatic drain_and_stop();
    while (q.size() != 0) @(posedge clk);
    #2;
    measure = 0;
    en_a = 0; en_b = 0;
    tick(12);
  endtask

  function automatic int max2(input int a, input int b); return (a > b) ? a : b; endfunction
  function automatic int min2(input int a, input int b); return (a < b) ? a : b; endfunction

  initial begin
    tick(3);
    // R10 reset state
    check(pull_a == 0, "R10 pull in reset", int'(pull_a), 0);
    check(!rise_a && !fall_a, "R10 strobes in reset", int'({rise_a, fall_a}), 0);
    rst_n = 1;
    tick(3);
    check(pull_a == 0 && bus == 1, "R10 pull after reset", int'(pull_a), 0);

    // R1 R3 R4 single master
    lo_a = 5; hi_a = 3;
    push(5 + 4, 3 + 4, 4, "R1 R3 R4 single");
    measure = 1; en_a = 1;
    drain_and_stop();

    // R3 R4 zero counts
    lo_a = 0; hi_a = 0;
    push(4, 4, 4, "R3 R4 zero count");
    measure = 1; en_a = 1;
    drain_and_stop();

    // R3 R4 full-scale counts
    lo_a = 63; hi_a = 63;
    push(67, 67, 2, "R3 R4 max count");
    measure = 1; en_a = 1;
    drain_and_stop();

    // R9 mid-phase change
    lo_a = 5; hi_a = 3;
    q.push_back('{1'b1, 9, "R9 before change low"});
    q.push_back('{1'b0, 7, "R9 before change high"});
    q.push_back('{1'b1, 9, "R9 low kept old value"});
    q.push_back('{1'b0, 12, "R9 high new value"});
    q.push_back('{1'b1, 6, "R9 low new value"});
    q.push_back('{1'b0, 12, "R9 high new value 2"});
    measure = 1; en_a = 1;
    while (q.size() != 4) @(posedge clk);
    tick(3);
    lo_a = 2; hi_a = 8;
    drain_and_stop();

    // R5 R6 R7 two masters, A has the long high
    lo_a = 3; hi_a = 10; lo_b = 12; hi_b = 5;
    rel_while_low = 0;
    push(max2(3, 12) + 4, min2(10, 5) + 4, 4, "R5 R6 R7 two masters");
    measure = 1; en_a = 1; en_b = 1;
    drain_and_stop();
    check(rel_while_low > 0, "R1 released while line held by peer", rel_while_low, 1);

    // R5 R6 R7 roles swapped
    lo_a = 20; hi_a = 2; lo_b = 2; hi_b = 20;
    push(max2(20, 2) + 4, min2(2, 20) + 4, 3, "R5 R6 R7 swapped");
    measure = 1; en_a = 1; en_b = 1;
    drain_and_stop();

    // R8 disabled node stays quiet while peer runs
    lo_a = 1; hi_a = 1; lo_b = 4; hi_b = 6;
    quiet_viol = 0; quiet_watch = 1;
    push(8, 10, 4, "R8 peer alone");
    measure = 1; en_b = 1;
    drain_and_stop();
    quiet_watch = 0;
    check(quiet_viol == 0, "R8 disabled node activity", quiet_viol, 0);

    // R8 re-enable starts cleanly
    lo_a = 1; hi_a = 2;
    push(5, 6, 3, "R8 re-enable");
    measure = 1; en_a = 1;
    drain_and_stop();
    check(pull_a == 0, "R8 released after disable", int'(pull_a), 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule